// File: doc/BRIEF.md
# Base-Limit Address Relocation and Protection Unit

This unit sits between a user process and main memory when memory is allocated contiguously. Privileged software loads two values through a small register port. The relocation base is the lowest physical address the process may touch. The limit is the size of the process's legal logical range. It is a byte count and not an end address.

Each logical address arrives on a valid/ready channel. The unit checks that address against the limit. When the check passes, it adds the base and sends the result to memory on a second valid/ready channel. An illegal address is completed on the request side, but no memory access is issued. Instead the unit raises a protection fault for one cycle. The process only ever sees logical addresses.

A supervisor qualifier on each request lets privileged code reach physical memory directly, with no relocation and no check.

Top module: `reloc_unit`

## Requirements
- R1: After synchronous reset, `mem_valid` and `fault` are low, and both base and limit hold 0. With a zero limit, every user-mode request faults.
- R2: A user-mode request whose logical address is strictly below the limit, and whose sum with the base fits in `PA_W` bits, produces `mem_valid` high in the cycle after acceptance. In that cycle `mem_addr` equals base plus the address.
- R3: A user-mode request whose logical address is greater than or equal to the limit raises `fault` for exactly one cycle, the cycle after acceptance, and leaves `mem_valid` low. `fault` and `mem_valid` are never high together.
- R4: A user-mode request whose base-plus-address sum carries out of `PA_W` bits also faults, with no memory request, even when the address is below the limit.
- R5: A request accepted with `req_super` high is forwarded with `mem_addr` equal to the zero-extended logical address. The limit and the base are ignored, and it never faults.
- R6: A configuration write with `cfg_sel`=0 loads the base from `cfg_wdata`. With `cfg_sel`=1 it loads the limit from `cfg_wdata[LA_W:0]`. A request accepted in the same cycle as a write uses the old values. A request accepted in a later cycle uses the new values.
- R7: A faulting request is accepted normally: `req_ready` is high in the cycle after the fault request is accepted.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_addr` and `mem_valid` hold and `req_ready` is low. The output drains one cycle after `mem_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects base, 1 selects limit |
| cfg_wdata | input | PA_W | Configuration write data |
| req_valid | input | 1 | Logical request valid |
| req_ready | output | 1 | Logical request accepted when high with valid |
| req_addr | input | LA_W | Logical address |
| req_super | input | 1 | Supervisor qualifier: bypass relocation and check |
| mem_valid | output | 1 | Physical request valid |
| mem_ready | input | 1 | Memory accepts physical request |
| mem_addr | output | PA_W | Physical address |
| fault | output | 1 | One-cycle protection fault pulse |

## Verification
A configuration write and a request acceptance can happen in the same clock cycle. Which register value applies to that request is the subtle point. The bench provokes this by driving a base write and a user request on the same edge. It checks that this request is relocated by the old base and that the next request uses the new one. The same is done for the limit, where the old and new values lead to opposite pass and fault outcomes.

// File: rtl/reloc_pkg.sv
package reloc_pkg;

    typedef enum logic [1:0] {
        VD_PASS      = 2'd0,
        VD_BYPASS    = 2'd1,
        VD_OUT_RANGE = 2'd2,
        VD_WRAP      = 2'd3
    } verdict_e;

    localparam logic SEL_BASE  = 1'b0;
    localparam logic SEL_LIMIT = 1'b1;

    function automatic logic verdict_forwards(input verdict_e v);
        return (v == VD_PASS) || (v == VD_BYPASS);
    endfunction

    function automatic logic verdict_faults(input verdict_e v);
        return (v == VD_OUT_RANGE) || (v == VD_WRAP);
    endfunction

endpackage

// File: rtl/reloc_regs.sv
module reloc_regs
    import reloc_pkg::*;
#(
    parameter int LA_W = 16,
    parameter int PA_W = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic            cfg_sel,
    input  logic [PA_W-1:0] cfg_wdata,
    output logic [PA_W-1:0] base_o,
    output logic [LA_W:0]   limit_o
);

    logic [PA_W-1:0] base_q;
    logic [LA_W:0]   limit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            limit_q <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_BASE) begin
                base_q <= cfg_wdata;
            end else begin
                limit_q <= cfg_wdata[LA_W:0];
            end
        end
    end

    assign base_o  = base_q;
    assign limit_o = limit_q;

endmodule

// File: rtl/reloc_check.sv
module reloc_check
    import reloc_pkg::*;
#(
    parameter int LA_W = 16,
    parameter int PA_W = 20
) (
    input  logic [PA_W-1:0] base_i,
    input  logic [LA_W:0]   limit_i,
    input  logic [LA_W-1:0] addr_i,
    input  logic            super_i,
    output verdict_e        verdict_o,
    output logic [PA_W-1:0] phys_o
);

    localparam int EXT_W = PA_W - LA_W;

    logic [PA_W-1:0] addr_ext;
    logic [PA_W:0]   sum;
    logic            beyond;
    logic            carry;

    always_comb begin
        addr_ext = {{EXT_W{1'b0}}, addr_i};
        sum      = {1'b0, base_i} + {1'b0, addr_ext};
        carry    = sum[PA_W];
        beyond   = ({1'b0, addr_i} >= limit_i);

        if (super_i) begin
            verdict_o = VD_BYPASS;
            phys_o    = addr_ext;
        end else if (beyond) begin
            verdict_o = VD_OUT_RANGE;
            phys_o    = '0;
        end else if (carry) begin
            verdict_o = VD_WRAP;
            phys_o    = '0;
        end else begin
            verdict_o = VD_PASS;
            phys_o    = sum[PA_W-1:0];
        end
    end

endmodule

// File: rtl/reloc_out.sv
module reloc_out
    import reloc_pkg::*;
#(
    parameter int PA_W = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take_i,
    input  verdict_e        verdict_i,
    input  logic [PA_W-1:0] phys_i,
    input  logic            mem_ready,
    output logic            mem_valid,
    output logic [PA_W-1:0] mem_addr,
    output logic            fault,
    output logic            room_o
);

    logic            valid_q;
    logic [PA_W-1:0] addr_q;
    logic            fault_q;

    assign room_o = !valid_q || mem_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            fault_q <= 1'b0;
        end else if (take_i) begin
            valid_q <= verdict_forwards(verdict_i);
            fault_q <= verdict_faults(verdict_i);
            if (verdict_forwards(verdict_i)) begin
                addr_q <= phys_i;
            end
        end else begin
            fault_q <= 1'b0;
            if (mem_ready) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign mem_valid = valid_q;
    assign mem_addr  = addr_q;
    assign fault     = fault_q;

endmodule

// File: rtl/reloc_unit.sv
module reloc_unit
    import reloc_pkg::*;
#(
    parameter int LA_W = 16,
    parameter int PA_W = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic            cfg_sel,
    input  logic [PA_W-1:0] cfg_wdata,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [LA_W-1:0] req_addr,
    input  logic            req_super,
    output logic            mem_valid,
    input  logic            mem_ready,
    output logic [PA_W-1:0] mem_addr,
    output logic            fault
);

    logic [PA_W-1:0] base_w;
    logic [LA_W:0]   limit_w;
    verdict_e        verdict_w;
    logic [PA_W-1:0] phys_w;
    logic            room_w;
    logic            take_w;

    reloc_regs #(.LA_W(LA_W), .PA_W(PA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .base_o    (base_w),
        .limit_o   (limit_w)
    );

    reloc_check #(.LA_W(LA_W), .PA_W(PA_W)) u_check (
        .base_i    (base_w),
        .limit_i   (limit_w),
        .addr_i    (req_addr),
        .super_i   (req_super),
        .verdict_o (verdict_w),
        .phys_o    (phys_w)
    );

    assign req_ready = room_w;
    assign take_w    = req_valid && room_w;

    reloc_out #(.PA_W(PA_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .take_i    (take_w),
        .verdict_i (verdict_w),
        .phys_i    (phys_w),
        .mem_ready (mem_ready),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .fault     (fault),
        .room_o    (room_w)
    );

endmodule

// File: rtl/reloc_unit_chk.sv
module reloc_unit_chk #(
    parameter int LA_W = 16,
    parameter int PA_W = 20
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic [LA_W-1:0] req_addr,
    input logic            req_super,
    input logic            mem_valid,
    input logic            mem_ready,
    input logic [PA_W-1:0] mem_addr,
    input logic            fault
);

    AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> (!mem_valid && !fault)); // R1

    AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        fault |-> $past(req_valid && req_ready && !req_super)); // R3

    AST_NO_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(fault && mem_valid)); // R3

    AST_SUPER_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_super) |=> (!fault && mem_valid
            && mem_addr == PA_W'($past(req_addr)))); // R5

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr))); // R8

    AST_STALL: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |-> !req_ready); // R8

    AST_FAULT_DONE: assert property (@(posedge clk) disable iff (rst)
        fault |-> req_ready); // R7

endmodule

bind reloc_unit reloc_unit_chk #(.LA_W(LA_W), .PA_W(PA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_super (req_super),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .fault     (fault)
);

// File: tb/reloc_unit_tb.sv
module reloc_unit_tb;

    localparam int LA_W = 4;
    localparam int PA_W = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_we = 1'b0;
    logic            cfg_sel = 1'b0;
    logic [PA_W-1:0] cfg_wdata = '0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [LA_W-1:0] req_addr = '0;
    logic            req_super = 1'b0;
    logic            mem_valid;
    logic            mem_ready = 1'b1;
    logic [PA_W-1:0] mem_addr;
    logic            fault;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    reloc_unit #(.LA_W(LA_W), .PA_W(PA_W)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_super(req_super), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .fault(fault)
    );

    task automatic check(input string req, input logic ok, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = PA_W'(val);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue one request, sample outputs in the cycle after acceptance.
    task automatic issue(input int addr, input logic sup);
        @(negedge clk);
        req_valid = 1'b1; req_addr = LA_W'(addr); req_super = sup;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_result(input string req, input logic ev, input int ea, input logic ef);
        check(req, mem_valid == ev, int'(mem_valid), int'(ev));
        check(req, fault == ef, int'(fault), int'(ef));
        if (ev) check(req, int'(mem_addr) == ea, int'(mem_addr), ea);
    endtask

    initial begin
        #(200000 * 10);
        $display("FAIL watchdog expired actual=0 expected=1");
        total++; bad++;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 mem_valid", mem_valid == 1'b0, int'(mem_valid), 0);
        check("R1 fault", fault == 1'b0, int'(fault), 0);
        check("R1 ready", req_ready == 1'b1, int'(req_ready), 1);
        issue(0, 1'b0);
        expect_result("R1 zero limit faults", 1'b0, 0, 1'b1);

        // Sweep: R2 R3 R4 R5 over base, limit, address and mode
        for (int b = 0; b < 64; b += 3) begin
            write_cfg(1'b0, b);
            for (int l = 0; l <= 16; l += 2) begin
                write_cfg(1'b1, l);
                for (int a = 0; a < 16; a++) begin
                    for (int s = 0; s < 2; s++) begin
                        logic ev, ef;
                        int ea;
                        if (s == 1) begin
                            ev = 1'b1; ef = 1'b0; ea = a;
                            issue(a, 1'b1);
                            expect_result("R5 bypass", ev, ea, ef);
                        end else begin
                            ea = b + a;
                            if (a >= l) begin
                                ev = 1'b0; ef = 1'b1;
                                issue(a, 1'b0);
                                expect_result("R3 beyond limit", ev, ea, ef);
                            end else if (ea >= 64) begin
                                ev = 1'b0; ef = 1'b1;
                                issue(a, 1'b0);
                                expect_result("R4 wrap", ev, ea, ef);
                            end else begin
                                ev = 1'b1; ef = 1'b0;
                                issue(a, 1'b0);
                                expect_result("R2 relocate", ev, ea, ef);
                            end
                        end
                    end
                end
            end
        end

        // R7: fault completes handshake; fault lasts one cycle
        write_cfg(1'b0, 5);
        write_cfg(1'b1, 4);
        issue(9, 1'b0);
        check("R7 ready after fault", req_ready == 1'b1, int'(req_ready), 1);
        check("R3 fault high", fault == 1'b1, int'(fault), 1);
        @(negedge clk);
        check("R3 fault one cycle", fault == 1'b0, int'(fault), 0);

        // R6: base write in same cycle as request uses old base
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 6'd20;
        req_valid = 1'b1; req_addr = 4'd1; req_super = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        expect_result("R6 same-cycle old base", 1'b1, 6, 1'b0);
        issue(1, 1'b0);
        expect_result("R6 new base", 1'b1, 21, 1'b0);

        // R6: limit write in same cycle; old limit 4 makes addr 6 fault
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 6'd10;
        req_valid = 1'b1; req_addr = 4'd6; req_super = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        expect_result("R6 same-cycle old limit", 1'b0, 0, 1'b1);
        issue(6, 1'b0);
        expect_result("R6 new limit", 1'b1, 26, 1'b0);

        // R8: backpressure
        @(negedge clk);
        mem_ready = 1'b0;
        issue(2, 1'b0);
        expect_result("R8 held start", 1'b1, 22, 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8 hold valid", mem_valid == 1'b1, int'(mem_valid), 1);
            check("R8 hold addr", int'(mem_addr) == 22, int'(mem_addr), 22);
            check("R8 stall ready", req_ready == 1'b0, int'(req_ready), 0);
        end
        mem_ready = 1'b1;
        @(negedge clk);
        check("R8 drained", mem_valid == 1'b0, int'(mem_valid), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule